// File: doc/BRIEF.md
# Buck Switch PWM Timer with Sense Trigger

This block drives the power switch of a buck converter with an edge-aligned pulse train and schedules the output-voltage sample for the loop. A free-running up-counter sets the switching period. The gate stays high while the count is below the duty compare value. A second, independent compare value picks the count at which a one-cycle start-of-conversion pulse goes to the sense ADC. The sample point can therefore sit anywhere in the period, away from the instant the switch opens.

Software or a controller writes the period, duty and trigger values through one small write port. Each write lands in a staging copy. All three active values change together only at a period boundary, so a period never runs with a mix of old and new values. When the ADC reports end of conversion, the block raises a one-cycle update request that starts the control-law computation. With a 100 MHz clock, the default period of 5000 counts gives a 20 kHz switching rate.

Top module: `buck_pwm_timer`

## Requirements
- R1: While `rst_n` is low, and for two clock edges after it rises, `gate_o`, `soc_o` and `upd_o` are low. The counter sits at 0, the period and the trigger value are both DEF_PERIOD, and the duty value is 0. Counting starts on the third edge after release.
- R2: The counter runs 0, 1, ..., P-1 and then returns to 0, where P is the active period. A P of 0 or 1 gives a period one count long. `gate_o` is high exactly while the current count is below the active duty value.
- R3: An active duty value of 0 keeps `gate_o` low for the whole period.
- R4: An active duty value of P or more, with P non-zero, keeps `gate_o` high for the whole period.
- R5: `soc_o` is high for one cycle, in the cycle the count equals the active trigger value. With P of 2 or more, it fires at most once per period.
- R6: An active trigger value of P or more, with P non-zero, produces no `soc_o` pulse.
- R7: When `wr_en_i` is high, `wr_sel_i` chooses which staging value takes `wr_data_i`: 0 selects the period, 1 the duty and 2 the trigger. All active values take the staged values on the edge where the count leaves P-1. A write presented in that same cycle is included. The period that is running keeps its old values.
- R8: A rising edge of `eoc_i` makes `upd_o` high for exactly one cycle, starting on the next clock edge. Holding `eoc_i` high does not repeat the pulse.
- R9: A write with `wr_sel_i` equal to 3 changes no staged or active value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe for the staging values |
| wr_sel_i | input | 2 | Target: 0 period, 1 duty, 2 trigger, 3 none |
| wr_data_i | input | CNT_W | Value to stage |
| eoc_i | input | 1 | End-of-conversion level from the ADC |
| gate_o | output | 1 | Switch gate drive |
| soc_o | output | 1 | Start-of-conversion pulse |
| upd_o | output | 1 | Controller update request |

## Verification
`gate_o` and `soc_o` come from registers fed by the next count and the next active values. Both therefore describe the count that is held after the same edge, with no added lag. A staged write shows on the outputs only from the first count 0 after that write. `upd_o` rises on the first edge at which `eoc_i` is seen high. The bench steps a reference model on each rising edge, with inputs changed on falling edges. It compares the outputs one nanosecond after the rising edge. The comparison therefore always sees the settled result of that edge and never a value in transit.

// File: rtl/buck_pwm_pkg.sv
package buck_pwm_pkg;
  typedef enum logic [1:0] {
    SEL_PERIOD = 2'd0,
    SEL_DUTY   = 2'd1,
    SEL_TRIG   = 2'd2,
    SEL_NONE   = 2'd3
  } wr_sel_e;

  localparam int NUM_CMP = 3;
endpackage

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] per_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] cnt_nx_o,
  output logic         last_o
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         last;

  always_comb begin
    last  = (per_i <= W'(1)) || (cnt_q >= (per_i - W'(1)));
    cnt_d = last ? '0 : (cnt_q + W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o    = cnt_q;
  assign cnt_nx_o = cnt_d;
  assign last_o   = last;
endmodule

// File: rtl/pwm_shadow_reg.sv
module pwm_shadow_reg #(
  parameter int           W       = 16,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  logic [W-1:0] data_i,
  input  logic         load_i,
  output logic [W-1:0] act_o,
  output logic [W-1:0] act_nx_o
);
  logic [W-1:0] stage_q, stage_d;
  logic [W-1:0] act_q, act_d;

  always_comb begin
    stage_d = wr_i   ? data_i  : stage_q;
    act_d   = load_i ? stage_d : act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= RST_VAL;
      act_q   <= RST_VAL;
    end else begin
      stage_q <= stage_d;
      act_q   <= act_d;
    end
  end

  assign act_o    = act_q;
  assign act_nx_o = act_d;
endmodule

// File: rtl/pwm_edge_pulse.sv
module pwm_edge_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic pulse_o
);
  logic lvl_q, pulse_q, pulse_d;

  always_comb pulse_d = lvl_i & ~lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      lvl_q   <= lvl_i;
      pulse_q <= pulse_d;
    end
  end

  assign pulse_o = pulse_q;
endmodule

// File: rtl/buck_pwm_timer.sv
module buck_pwm_timer
  import buck_pwm_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int DEF_PERIOD = 5000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_sel_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             eoc_i,
  output logic             gate_o,
  output logic             soc_o,
  output logic             upd_o
);
  localparam logic [CNT_W-1:0] PER_RST = CNT_W'(DEF_PERIOD);
  localparam logic [CNT_W-1:0] CMP_RST [NUM_CMP] = '{PER_RST, '0, PER_RST};

  // reset: asserted at once, released through two flops
  logic [1:0] rs_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  logic [CNT_W-1:0] act    [NUM_CMP];
  logic [CNT_W-1:0] act_nx [NUM_CMP];
  logic [CNT_W-1:0] cnt_q, cnt_nx;
  logic             cnt_last;
  logic [CNT_W-1:0] per_act, duty_act, trig_act;

  assign per_act  = act[SEL_PERIOD];
  assign duty_act = act[SEL_DUTY];
  assign trig_act = act[SEL_TRIG];

  pwm_counter #(.W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .per_i   (per_act),
    .cnt_o   (cnt_q),
    .cnt_nx_o(cnt_nx),
    .last_o  (cnt_last)
  );

  for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
    logic wr_hit;
    assign wr_hit = wr_en_i && (wr_sel_i == 2'(g));
    pwm_shadow_reg #(.W(CNT_W), .RST_VAL(CMP_RST[g])) u_sh (
      .clk     (clk),
      .rst_n   (rst_int_n),
      .wr_i    (wr_hit),
      .data_i  (wr_data_i),
      .load_i  (cnt_last),
      .act_o   (act[g]),
      .act_nx_o(act_nx[g])
    );
  end

  // outputs registered from the next count and next active values
  logic gate_q, gate_d, soc_q, soc_d;

  always_comb begin
    gate_d = cnt_nx <  act_nx[SEL_DUTY];
    soc_d  = cnt_nx == act_nx[SEL_TRIG];
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      gate_q <= 1'b0;
      soc_q  <= 1'b0;
    end else begin
      gate_q <= gate_d;
      soc_q  <= soc_d;
    end
  end

  pwm_edge_pulse u_eoc (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .lvl_i  (eoc_i),
    .pulse_o(upd_o)
  );

  assign gate_o = gate_q;
  assign soc_o  = soc_q;
endmodule

// File: rtl/buck_pwm_timer_chk.sv
module buck_pwm_timer_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         gate,
  input logic         soc,
  input logic         upd,
  input logic         eoc,
  input logic         last,
  input logic [W-1:0] cnt,
  input logic [W-1:0] per,
  input logic [W-1:0] duty,
  input logic [W-1:0] trig
);
  assert_cnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (per != '0) |-> (cnt < per));

  assert_gate_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (duty == '0) |-> !gate);

  assert_gate_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((per != '0) && (duty >= per)) |-> gate);

  assert_soc_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
    soc |-> (cnt == trig));

  assert_soc_none_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((per != '0) && (trig >= per)) |-> !soc);

  assert_shadow_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !last |=> ($stable(per) && $stable(duty) && $stable(trig)));

  assert_upd_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> !upd);

  assert_upd_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    upd |-> $past(eoc));
endmodule

bind buck_pwm_timer buck_pwm_timer_chk #(.W(CNT_W)) u_chk (
  .clk (clk),
  .rst_n(rst_int_n),
  .gate(gate_o),
  .soc (soc_o),
  .upd (upd_o),
  .eoc (eoc_i),
  .last(cnt_last),
  .cnt (cnt_q),
  .per (per_act),
  .duty(duty_act),
  .trig(trig_act)
);

// File: tb/buck_pwm_timer_test.sv
`timescale 1ns/100ps
module buck_pwm_timer_test;
  localparam int W  = 8;
  localparam int DP = 20;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         wr_en;
  logic [1:0]   wr_sel;
  logic [W-1:0] wr_data;
  logic         eoc;
  logic         gate_o, soc_o, upd_o;

  always #2.5 clk = ~clk;

  buck_pwm_timer #(.CNT_W(W), .DEF_PERIOD(DP)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .eoc_i(eoc),
    .gate_o(gate_o), .soc_o(soc_o), .upd_o(upd_o)
  );

  int n_run = 0, n_fail = 0, cycles = 0;
  bit chk_en = 0;

  // reference model state
  int m_cnt, m_per, m_duty, m_trig, s_per, s_duty, s_trig;
  bit m_gate, m_soc, m_upd, m_eoc_q, m_rs1, m_rs2;
  int rst_win = 0, r9_win = 0;

  function automatic bit is_last(int c, int p);
    return (p <= 1) || (c >= p - 1);
  endfunction

  task automatic model_reset();
    m_cnt = 0; m_per = DP; s_per = DP; m_duty = 0; s_duty = 0;
    m_trig = DP; s_trig = DP; m_gate = 0; m_soc = 0; m_upd = 0; m_eoc_q = 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rs1 = 0; m_rs2 = 0; model_reset(); rst_win = 4;
    end else begin
      if (!m_rs2) begin
        model_reset();
      end else begin
        if (wr_en && wr_sel == 2'd0) s_per  = int'(wr_data);
        if (wr_en && wr_sel == 2'd1) s_duty = int'(wr_data);
        if (wr_en && wr_sel == 2'd2) s_trig = int'(wr_data);
        if (is_last(m_cnt, m_per)) begin
          m_cnt = 0; m_per = s_per; m_duty = s_duty; m_trig = s_trig;
        end else begin
          m_cnt = m_cnt + 1;
        end
        m_gate = m_cnt < m_duty;
        m_soc  = m_cnt == m_trig;
        m_upd  = eoc && !m_eoc_q;
        m_eoc_q = eoc;
      end
      m_rs2 = m_rs1; m_rs1 = 1;
      if (rst_win > 0) rst_win--;
      if (r9_win > 0) r9_win--;
    end
  end

  task automatic check(string tag, bit act, bit exp, string what);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0b expected %0b (t=%0t)", tag, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (chk_en) begin
      string tg, ts;
      if (rst_win > 0 || !rst_n)            tg = "R1";
      else if (r9_win > 0)                   tg = "R9";
      else if (s_duty != m_duty)             tg = "R7";
      else if (m_duty == 0)                  tg = "R3";
      else if (m_per != 0 && m_duty >= m_per) tg = "R4";
      else                                   tg = "R2";
      if (rst_win > 0 || !rst_n)            ts = "R1";
      else if (m_per != 0 && m_trig >= m_per) ts = "R6";
      else                                   ts = "R5";
      check(tg, gate_o, m_gate, "gate_o");
      check(ts, soc_o, m_soc, "soc_o");
      check((rst_win > 0 || !rst_n) ? "R1" : "R8", upd_o, m_upd, "upd_o");
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected <= 200000", cycles);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic wr(logic [1:0] s, int d);
    @(negedge clk);
    wr_en = 1; wr_sel = s; wr_data = W'(d);
    if (s == 2'd3) r9_win = 3 * DP;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    rst_n = 0; wr_en = 0; wr_sel = 0; wr_data = '0; eoc = 0;
    void'($urandom(32'd20240611));
    chk_en = 1;
    idle(3);
    rst_n = 1;                      // R1: release and hold-off
    idle(2 * DP);
    wr(2'd1, 0);   idle(2 * DP);    // R3: duty zero
    wr(2'd1, 25);  idle(2 * DP);    // R4: duty beyond period
    wr(2'd1, 7);   wr(2'd2, 5); idle(2 * DP);   // R2, R5
    wr(2'd2, 30);  idle(2 * DP);    // R6: trigger outside period
    wr(2'd2, 19);  idle(2 * DP);    // R5: trigger at last count
    idle(9); wr(2'd1, 12); idle(2 * DP);        // R7: mid-period write
    wr(2'd3, 1);   idle(2 * DP);    // R9: unused selector
    wr(2'd0, 7);   idle(3 * DP);    // R7: period change
    wr(2'd0, 1);   idle(8);         // R2: one-count period
    wr(2'd0, 0);   idle(8);
    wr(2'd0, 20);  idle(2 * DP);
    eoc = 1; idle(6); eoc = 0; idle(3);         // R8: held level
    eoc = 1; idle(1); eoc = 0; idle(4);
    idle(5); rst_n = 0; idle(2); rst_n = 1; idle(DP);   // R1 again
    for (int i = 0; i < 15000; i++) begin
      @(negedge clk);
      wr_en = ($urandom % 8) == 0;
      wr_sel = 2'($urandom % 4);
      if (wr_sel == 2'd0) wr_data = W'(($urandom % 16 == 0) ? 0 : 1 + $urandom % 40);
      else                wr_data = W'($urandom % 46);
      if (wr_en && wr_sel == 2'd3) r9_win = 2;
      if ($urandom % 4 == 0) eoc = ~eoc;
    end
    @(negedge clk); wr_en = 0;
    idle(4);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule